// File: doc/BRIEF.md
# Key-Locked Flash Write Controller

This block sits between the data-write port of an 8-bit processor and an on-chip flash array. A data write reaches the flash only when three things are true. Software has set the program-store write-enable bit. The erase-enable bit is clear. The key register has just received the two-value unlock sequence. While write-enable is clear, the same data writes go to ordinary external RAM instead.

The controller has two commit modes. In byte mode, every accepted write starts one program operation at once. In pair mode, the write to the even address of a two-byte block is held in a buffer. When the matching odd-address write arrives, both bytes are committed in a single program operation of the same length. Every data write, even or odd, spends its own unlock. A wrong key, a key out of sequence, or an odd write in pair mode with no even byte held locks the flash until reset. A byte written as 0xFF has its lane enable dropped, so that cell is left as it was.

Top module: `flash_write_guard`

## Requirements
- R1: While reset is asserted and just after it, fl_prog_o, busy_o and ram_we_o are low.
- R2: A flash data write is accepted only when the key register (reg_sel_i=0) has received 0xA5 and then 0xF1. An unaccepted write produces no fl_prog_o pulse.
- R3: A key value other than the expected one, or any key write once unlocked, locks the controller. After that no flash write is accepted, even after a correct key sequence, until reset.
- R4: In byte mode (control bit 2 clear), an accepted write pulses fl_prog_o for one cycle, one cycle after the write. fl_addr_o is the address with bit 0 cleared. The byte appears on lane dat_addr_i[0] of fl_data_o (lane 0 = bits 7:0) with the other lane 0xFF, and fl_be_o enables only that lane.
- R5: An unlock is spent by exactly one accepted data write. A following write with no new key sequence is ignored.
- R6: In pair mode (control bit 2 set), an even-address write produces no program pulse. The next accepted odd write to the same block pulses fl_prog_o once, with the even byte on lane 0, the odd byte on lane 1 and the even address on fl_addr_o.
- R7: In pair mode, an odd-address write with no even byte held for that block locks the controller, as in R3.
- R8: A lane whose byte is 0xFF has its fl_be_o bit cleared, in both modes.
- R9: busy_o is high for PROG_CYCLES cycles from each program pulse, for both byte and pair commits. Data writes during busy are ignored and do not spend the unlock.
- R10: Control register (reg_sel_i=1) bit 0 is write-enable and bit 1 is erase-enable. With write-enable clear, a data write pulses ram_we_o one cycle later with its address and data and starts no program. With erase-enable set, a data write reaches neither flash nor RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 key, 1 control |
| reg_wdata_i | input | 8 | Register write data |
| dat_we_i | input | 1 | Data write strobe |
| dat_addr_i | input | ADDR_W | Data write byte address |
| dat_wdata_i | input | 8 | Data write byte |
| fl_prog_o | output | 1 | One-cycle program strobe to the flash |
| fl_addr_o | output | ADDR_W | Block-aligned program address |
| fl_data_o | output | 16 | Program data, two byte lanes |
| fl_be_o | output | 2 | Lane enables |
| busy_o | output | 1 | Program operation in progress |
| ram_we_o | output | 1 | External RAM write strobe |
| ram_addr_o | output | ADDR_W | External RAM write address |
| ram_wdata_o | output | 8 | External RAM write data |

## Verification
A key or control write takes effect at the clock edge that samples it. A data write's program pulse or RAM strobe, with its address, data and lane enables, shows one edge later. busy_o rises together with the program pulse and stays high for PROG_CYCLES sampled cycles. The bench drives every input on the falling edge and holds it for one full cycle. It reads the strobes and buses on the next falling edge, which is the single cycle where a pulse is visible. To count busy, it samples once per falling edge until the signal drops.

// File: rtl/fwg_pkg.sv
package fwg_pkg;
  localparam int LANES = 2;
  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'hF1;
  localparam logic [7:0] BLANK      = 8'hFF;

  // control register bit positions
  localparam int CTL_WEN  = 0;
  localparam int CTL_ERS  = 1;
  localparam int CTL_PAIR = 2;
  localparam int CTL_W    = 3;

  typedef enum logic [1:0] {
    KS_IDLE   = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2,
    KS_LOCKED = 2'd3
  } key_state_e;
endpackage

// File: rtl/fwg_key_unlock.sv
module fwg_key_unlock
  import fwg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_we_i,
  input  logic [7:0] key_i,
  input  logic       consume_i,
  input  logic       fail_i,
  output logic       open_o,
  output key_state_e state_o
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (st_q != KS_LOCKED) begin
      if (fail_i)         st_d = KS_LOCKED;
      else if (consume_i) st_d = KS_IDLE;   // spent unlock wins over a same-cycle key
      else if (key_we_i) begin
        unique case (st_q)
          KS_IDLE: st_d = (key_i == KEY_FIRST)  ? KS_HALF : KS_LOCKED;
          KS_HALF: st_d = (key_i == KEY_SECOND) ? KS_OPEN : KS_LOCKED;
          default: st_d = KS_LOCKED;           // key after unlock is out of order
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KS_IDLE;
    else         st_q <= st_d;
  end

  assign open_o  = (st_q == KS_OPEN);
  assign state_o = st_q;
endmodule

// File: rtl/fwg_pair_buf.sv
module fwg_pair_buf #(
  parameter int BLK_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             store_i,
  input  logic             clr_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [7:0]       byte_i,
  output logic             pend_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [7:0]       byte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      blk_o  <= '0;
      byte_o <= '0;
    end else if (store_i) begin
      pend_o <= 1'b1;
      blk_o  <= blk_i;
      byte_o <= byte_i;
    end else if (clr_i) begin
      pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fwg_prog_timer.sv
module fwg_prog_timer #(
  parameter int PROG_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CNT_W'(PROG_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/flash_write_guard.sv
module flash_write_guard
  import fwg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PROG_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              dat_we_i,
  input  logic [ADDR_W-1:0] dat_addr_i,
  input  logic [7:0]        dat_wdata_i,
  output logic              fl_prog_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [LANES*8-1:0] fl_data_o,
  output logic [LANES-1:0]  fl_be_o,
  output logic              busy_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o
);
  localparam int BLK_W = ADDR_W - 1;

  logic [CTL_W-1:0] ctl_q;
  logic             key_open, pend, accept, is_odd;
  logic             single_go, even_store, odd_ok, odd_bad, prog_go, consume;
  logic             to_flash, to_ram;
  logic [BLK_W-1:0] pend_blk;
  logic [7:0]       pend_byte;
  key_state_e       key_state;
  logic [LANES-1:0][7:0] lane_byte;
  logic [LANES-1:0]      lane_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ctl_q <= '0;
    else if (reg_we_i && reg_sel_i)  ctl_q <= reg_wdata_i[CTL_W-1:0];
  end

  assign to_flash   = dat_we_i && ctl_q[CTL_WEN] && !ctl_q[CTL_ERS];
  assign to_ram     = dat_we_i && !ctl_q[CTL_WEN];
  assign accept     = to_flash && key_open && !busy_o;
  assign is_odd     = dat_addr_i[0];
  assign single_go  = accept && !ctl_q[CTL_PAIR];
  assign even_store = accept && ctl_q[CTL_PAIR] && !is_odd;
  assign odd_ok     = accept && ctl_q[CTL_PAIR] && is_odd && pend
                      && (pend_blk == dat_addr_i[ADDR_W-1:1]);
  assign odd_bad    = accept && ctl_q[CTL_PAIR] && is_odd && !odd_ok;
  assign prog_go    = single_go || odd_ok;
  assign consume    = single_go || even_store || odd_ok;

  fwg_key_unlock i_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_we_i  (reg_we_i && !reg_sel_i),
    .key_i     (reg_wdata_i),
    .consume_i (consume),
    .fail_i    (odd_bad),
    .open_o    (key_open),
    .state_o   (key_state)
  );

  fwg_pair_buf #(.BLK_W(BLK_W)) i_pair (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .store_i (even_store),
    .clr_i   (odd_ok || !ctl_q[CTL_PAIR]),
    .blk_i   (dat_addr_i[ADDR_W-1:1]),
    .byte_i  (dat_wdata_i),
    .pend_o  (pend),
    .blk_o   (pend_blk),
    .byte_o  (pend_byte)
  );

  fwg_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (prog_go),
    .busy_o (busy_o)
  );

  // lane steering: pair mode takes held even byte on lane 0
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_byte[g] = ctl_q[CTL_PAIR]
                          ? ((g == 0) ? pend_byte : dat_wdata_i)
                          : ((dat_addr_i[0] == 1'(g)) ? dat_wdata_i : BLANK);
    assign lane_en[g]   = (lane_byte[g] != BLANK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_prog_o   <= 1'b0;
      fl_addr_o   <= '0;
      fl_data_o   <= '0;
      fl_be_o     <= '0;
      ram_we_o    <= 1'b0;
      ram_addr_o  <= '0;
      ram_wdata_o <= '0;
    end else begin
      fl_prog_o <= prog_go;
      ram_we_o  <= to_ram;
      if (prog_go) begin
        fl_addr_o <= {dat_addr_i[ADDR_W-1:1], 1'b0};
        fl_data_o <= lane_byte;
        fl_be_o   <= lane_en;
      end
      if (to_ram) begin
        ram_addr_o  <= dat_addr_i;
        ram_wdata_o <= dat_wdata_i;
      end
    end
  end
endmodule

// File: rtl/fwg_checker.sv
module fwg_checker
  import fwg_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dat_we_i,
  input logic       fl_prog_o,
  input logic       busy_o,
  input logic       ram_we_o,
  input key_state_e key_state
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!fl_prog_o && !busy_o && !ram_we_o);
    end
  end

  a_r2_prog_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_prog_o |-> $past(dat_we_i));

  a_r3_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_state == KS_LOCKED |=> key_state == KS_LOCKED);

  a_r5_unlock_spent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_prog_o |-> key_state != KS_OPEN);

  a_r9_busy_with_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_prog_o |-> busy_o);

  a_r9_no_prog_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_prog_o |-> !$past(busy_o));

  a_r10_ram_flash_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && fl_prog_o));
endmodule

bind flash_write_guard fwg_checker i_fwg_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dat_we_i  (dat_we_i),
  .fl_prog_o (fl_prog_o),
  .busy_o    (busy_o),
  .ram_we_o  (ram_we_o),
  .key_state (key_state)
);

// File: tb/test_flash_write_guard.sv
`timescale 1ns/1ps
module test_flash_write_guard;
  localparam int AW = 16;
  localparam int PC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, reg_sel = 0;
  logic [7:0] reg_wd = 0;
  logic dat_we = 0;
  logic [AW-1:0] dat_addr = 0;
  logic [7:0] dat_wd = 0;
  logic fl_prog, busy, ram_we;
  logic [AW-1:0] fl_addr, ram_addr;
  logic [15:0] fl_data;
  logic [1:0] fl_be;
  logic [7:0] ram_wd;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  flash_write_guard #(.ADDR_W(AW), .PROG_CYCLES(PC)) i_flash_write_guard (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wd), .dat_we_i(dat_we), .dat_addr_i(dat_addr),
    .dat_wdata_i(dat_wd), .fl_prog_o(fl_prog), .fl_addr_o(fl_addr),
    .fl_data_o(fl_data), .fl_be_o(fl_be), .busy_o(busy), .ram_we_o(ram_we),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wd));

  // byte-mode vectors {addr, data}
  localparam logic [23:0] VEC [6] = '{
    {16'h0100, 8'h5A}, {16'h0101, 8'hC3}, {16'h0202, 8'h00},
    {16'h0203, 8'hFF}, {16'h7FFE, 8'h81}, {16'hFFFF, 8'h7E}};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic reg_wr(input logic sel, input logic [7:0] v);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wd = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic unlock();
    reg_wr(0, 8'hA5); reg_wr(0, 8'hF1);
  endtask

  // outputs of the write are valid when this returns
  task automatic data_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); dat_we = 1; dat_addr = a; dat_wd = d;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [AW-1:0] a;
    logic [7:0] d;
    #1;
    check("R1 prog in reset", {31'd0, fl_prog}, 0);
    check("R1 busy in reset", {31'd0, busy}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ram_we after reset", {31'd0, ram_we}, 0);

    // R2: no key, then half key
    reg_wr(1, 8'h01);
    data_wr(16'h0010, 8'h11);
    check("R2 no key no prog", {31'd0, fl_prog}, 0);
    reg_wr(0, 8'hA5);
    data_wr(16'h0010, 8'h11);
    check("R2 half key no prog", {31'd0, fl_prog}, 0);
    reg_wr(0, 8'hF1);
    data_wr(16'h0010, 8'h11);
    check("R2 full key prog", {31'd0, fl_prog}, 1);
    wait_idle();

    // R4/R8 vector table in byte mode
    for (int i = 0; i < 6; i++) begin
      a = VEC[i][23:8]; d = VEC[i][7:0];
      unlock();
      data_wr(a, d);
      check("R4 prog", {31'd0, fl_prog}, 1);
      check("R4 addr", {16'd0, fl_addr}, {16'd0, a[AW-1:1], 1'b0});
      check("R4 data", {16'd0, fl_data}, a[0] ? {16'd0, d, 8'hFF} : {16'd0, 8'hFF, d});
      check("R4 R8 be", {30'd0, fl_be},
            {30'd0, a[0] ? {d != 8'hFF, 1'b0} : {1'b0, d != 8'hFF}});
      wait_idle();
    end

    // R5: second write without key
    data_wr(16'h0020, 8'h22);
    check("R5 no reuse of unlock", {31'd0, fl_prog}, 0);

    // R9: busy length, byte mode
    unlock();
    data_wr(16'h0030, 8'h33);
    count_busy(n);
    check("R9 busy cycles byte", n, PC);

    // R9: write during busy ignored, unlock kept
    unlock();
    data_wr(16'h0040, 8'h44);
    unlock();
    data_wr(16'h0042, 8'h46);
    check("R9 write in busy ignored", {31'd0, fl_prog}, 0);
    wait_idle();
    data_wr(16'h0044, 8'h48);
    check("R9 unlock kept after busy", {31'd0, fl_prog}, 1);
    check("R9 addr after busy", {16'd0, fl_addr}, 32'h0044);
    wait_idle();

    // R6: pair mode
    reg_wr(1, 8'h05);
    unlock();
    data_wr(16'h0010, 8'h12);
    check("R6 even no prog", {31'd0, fl_prog}, 0);
    unlock();
    data_wr(16'h0011, 8'h34);
    check("R6 odd prog", {31'd0, fl_prog}, 1);
    check("R6 addr", {16'd0, fl_addr}, 32'h0010);
    check("R6 data", {16'd0, fl_data}, 32'h3412);
    check("R6 be", {30'd0, fl_be}, 3);
    count_busy(n);
    check("R9 busy cycles pair", n, PC);

    // R8 in pair mode
    unlock();
    data_wr(16'h0A00, 8'hFF);
    unlock();
    data_wr(16'h0A01, 8'h3C);
    check("R8 pair data", {16'd0, fl_data}, 32'h3CFF);
    check("R8 pair be", {30'd0, fl_be}, 2);
    wait_idle();

    // R7: odd with no even held
    unlock();
    data_wr(16'h0B01, 8'h55);
    check("R7 orphan odd no prog", {31'd0, fl_prog}, 0);
    unlock();
    data_wr(16'h0B00, 8'h66);
    unlock();
    data_wr(16'h0B01, 8'h77);
    check("R7 locked after orphan", {31'd0, fl_prog}, 0);
    do_reset();

    // R3: wrong key, out of order, extra key
    reg_wr(1, 8'h01);
    reg_wr(0, 8'h00);
    unlock();
    data_wr(16'h0C00, 8'h01);
    check("R3 wrong key locks", {31'd0, fl_prog}, 0);
    do_reset();
    reg_wr(1, 8'h01);
    reg_wr(0, 8'hF1);
    unlock();
    data_wr(16'h0C00, 8'h01);
    check("R3 out of order locks", {31'd0, fl_prog}, 0);
    do_reset();
    reg_wr(1, 8'h01);
    unlock();
    reg_wr(0, 8'hA5);
    unlock();
    data_wr(16'h0C00, 8'h01);
    check("R3 extra key locks", {31'd0, fl_prog}, 0);
    do_reset();

    // R10: RAM path and erase-enable
    reg_wr(1, 8'h00);
    unlock();
    data_wr(16'h1234, 8'hAB);
    check("R10 ram we", {31'd0, ram_we}, 1);
    check("R10 ram addr", {16'd0, ram_addr}, 32'h1234);
    check("R10 ram data", {24'd0, ram_wd}, 32'hAB);
    check("R10 no prog to ram", {31'd0, fl_prog}, 0);
    reg_wr(1, 8'h03);
    data_wr(16'h1236, 8'hCD);
    check("R10 erase blocks prog", {31'd0, fl_prog}, 0);
    check("R10 erase blocks ram", {31'd0, ram_we}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule